// File: doc/BRIEF.md
# Paged Non-Volatile Memory Programming Controller

This block sits behind a serial programming front end and acts on instructions that have already been decoded into an opcode, an address and a data byte. It collects program-memory words and data-memory bytes in two page buffers, then copies a buffer into a behavioural storage array when a commit instruction arrives. It also supports a direct single-byte data-memory write, read-back of any stored location, and a status poll.

A program-memory word is 16 bits wide and is assembled from two byte loads. The low byte must come first. Buffer loads look only at the in-page part of the address, and commits look only at the page part. After every commit or byte write a timer holds `busy` for a programmed number of cycles. During that time every instruction other than a poll or a no-op is refused and flagged, so a write cannot be disturbed.

Top module: `nvm_page_prog`

## Requirements
- R1: While reset is held and in the first cycle after its release, `busy`, `reject` and `rsp_valid` are 0.
- R2: Opcode 1 stores `cmd_data` as the pending low byte of word `cmd_addr[4:0]`, and opcode 2 completes that word with `cmd_data` as the high byte. Opcode 3 copies all 32 buffered words into page `cmd_addr[10:5]`. Opcodes 7 and 8 return the low and high byte of word `cmd_addr[10:0]`. Loads ignore address bits 10:5 and commits ignore bits 4:0.
- R3: Opcode 2 for a word with no pending low byte is refused: `reject` is 1 in the following cycle and the buffered word does not change.
- R4: After a commit, every word in the program-memory buffer reads as 16'hFFFF until it is loaded again, so words not loaded since the last commit are stored as all ones.
- R5: Opcode 4 places `cmd_data` into byte `cmd_addr[1:0]` of the data-memory buffer and marks that byte as loaded. Opcode 5 writes only the marked bytes into page `cmd_addr[7:2]`, leaves the other bytes of that page unchanged, and then clears all marks.
- R6: Opcode 6 replaces the data-memory byte at `cmd_addr[7:0]` with `cmd_data`. Opcode 9 reads back the byte at `cmd_addr[7:0]`.
- R7: An accepted opcode 3 holds `busy` high for exactly FL_WAIT cycles, and an accepted opcode 5 or 6 holds it high for exactly EE_WAIT cycles, starting in the cycle after the instruction.
- R8: Opcode 10 (poll) is accepted at any time. It returns `rsp_data` with bit 0 equal to `busy` as sampled with the instruction and bits 7:1 at 0.
- R9: While `busy` is high, opcodes 1 to 9 are refused: `reject` is 1 in the following cycle, and the instruction has no effect on either buffer or on either array.
- R10: `rsp_valid` pulses for one cycle, in the cycle after each accepted read or poll, and at no other time. Opcode 0 and codes 11 to 15 produce neither a response nor a refusal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | An instruction is present this cycle |
| cmd_op | input | 4 | Instruction opcode |
| cmd_addr | input | 11 | Instruction address |
| cmd_data | input | 8 | Instruction data byte |
| busy | output | 1 | A write is in progress |
| reject | output | 1 | The previous instruction was refused |
| rsp_valid | output | 1 | `rsp_data` holds a read or poll result |
| rsp_data | output | 8 | Read or poll result |

## Verification
The program-memory page is filled with words whose addresses carry unrelated page bits. One word is left out entirely, and one gets only a high byte. This separates correct use of the in-page bits and of the ordering rule from a buffer that accepts any byte order. A second page is committed from a buffer that has just been cleared, and it receives a low byte that was refused while busy. Its read-back shows whether the refusal and the refill with all ones really took effect. On the data-memory side, a page is written byte by byte and then partly overwritten through the page buffer. After that, a commit with no marks is issued, which shows whether the per-byte mask works and is cleared. Busy lengths are counted for both memory kinds, and polls are issued both while busy and while idle.

// File: rtl/nvm_prog_pkg.sv
package nvm_prog_pkg;
  typedef enum logic [3:0] {
    OP_NOP       = 4'd0,
    OP_FL_LO     = 4'd1,
    OP_FL_HI     = 4'd2,
    OP_FL_COMMIT = 4'd3,
    OP_EE_LOAD   = 4'd4,
    OP_EE_COMMIT = 4'd5,
    OP_EE_BYTE   = 4'd6,
    OP_RD_FL_LO  = 4'd7,
    OP_RD_FL_HI  = 4'd8,
    OP_RD_EE     = 4'd9,
    OP_POLL      = 4'd10
  } prog_op_e;
endpackage

// File: rtl/fl_page_buf.sv
module fl_page_buf #(
  parameter int WORD_W = 5,
  localparam int WORDS = 1 << WORD_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   ld_lo,
  input  logic                   ld_hi,
  input  logic                   clr,
  input  logic [WORD_W-1:0]      idx,
  input  logic [7:0]             din,
  output logic                   hi_orphan,
  output logic [WORDS-1:0][15:0] words
);
  logic [WORDS-1:0][15:0] words_q, words_d;
  logic [WORDS-1:0][7:0]  lo_q, lo_d;
  logic [WORDS-1:0]       pend_q, pend_d;
  logic                   upd_en;

  assign hi_orphan = ld_hi & ~pend_q[idx];
  assign upd_en    = clr | ld_lo | ld_hi;
  assign words     = words_q;

  always_comb begin
    words_d = words_q;
    lo_d    = lo_q;
    pend_d  = pend_q;
    if (clr) begin
      words_d = '1;
      pend_d  = '0;
    end else if (ld_lo) begin
      lo_d[idx]   = din;
      pend_d[idx] = 1'b1;
    end else if (ld_hi && pend_q[idx]) begin
      words_d[idx] = {din, lo_q[idx]};
      pend_d[idx]  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      words_q <= '1;
      lo_q    <= '0;
      pend_q  <= '0;
    end else if (upd_en) begin
      words_q <= words_d;
      lo_q    <= lo_d;
      pend_q  <= pend_d;
    end
  end
endmodule

// File: rtl/ee_page_buf.sv
module ee_page_buf #(
  parameter int BYTE_W = 2,
  localparam int BYTES = 1 << BYTE_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  ld,
  input  logic                  clr,
  input  logic [BYTE_W-1:0]     idx,
  input  logic [7:0]            din,
  output logic [BYTES-1:0][7:0] bytes,
  output logic [BYTES-1:0]      mask
);
  logic [BYTES-1:0][7:0] bytes_q, bytes_d;
  logic [BYTES-1:0]      mask_q, mask_d;
  logic                  upd_en;

  assign upd_en = ld | clr;
  assign bytes  = bytes_q;
  assign mask   = mask_q;

  always_comb begin
    bytes_d = bytes_q;
    mask_d  = mask_q;
    if (clr) begin
      mask_d = '0;
    end else if (ld) begin
      bytes_d[idx] = din;
      mask_d[idx]  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bytes_q <= '0;
      mask_q  <= '0;
    end else if (upd_en) begin
      bytes_q <= bytes_d;
      mask_q  <= mask_d;
    end
  end
endmodule

// File: rtl/prog_timer.sv
module prog_timer #(
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] load_val,
  output logic             busy
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign busy   = (cnt_q != '0);
  assign cnt_en = start | busy;

  always_comb begin
    if (start) cnt_d = load_val;
    else       cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/nvm_page_prog.sv
module nvm_page_prog #(
  parameter int FL_PAGE_W = 6,
  parameter int FL_WORD_W = 5,
  parameter int EE_PAGE_W = 6,
  parameter int EE_BYTE_W = 2,
  parameter int FL_WAIT   = 64,
  parameter int EE_WAIT   = 24,
  localparam int FL_ADDR_W = FL_PAGE_W + FL_WORD_W,
  localparam int EE_ADDR_W = EE_PAGE_W + EE_BYTE_W,
  localparam int ADDR_W    = (FL_ADDR_W > EE_ADDR_W) ? FL_ADDR_W : EE_ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [3:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [7:0]        cmd_data,
  output logic              busy,
  output logic              reject,
  output logic              rsp_valid,
  output logic [7:0]        rsp_data
);
  import nvm_prog_pkg::*;

  localparam int FL_WORDS = 1 << FL_WORD_W;
  localparam int EE_BYTES = 1 << EE_BYTE_W;
  localparam int FL_DEPTH = 1 << FL_ADDR_W;
  localparam int EE_DEPTH = 1 << EE_ADDR_W;
  localparam int WAIT_MAX = (FL_WAIT > EE_WAIT) ? FL_WAIT : EE_WAIT;
  localparam int CNT_W    = $clog2(WAIT_MAX + 1);

  prog_op_e op;
  logic     go, is_poll, is_read, blocked;
  logic     fl_lo, fl_hi, fl_commit, ee_load, ee_commit, ee_byte;
  logic     hi_orphan, tmr_start;
  logic [CNT_W-1:0] tmr_load;

  logic [FL_WORDS-1:0][15:0] fl_words;
  logic [EE_BYTES-1:0][7:0]  ee_bytes;
  logic [EE_BYTES-1:0]       ee_mask;

  logic [FL_ADDR_W-1:0] fl_addr;
  logic [EE_ADDR_W-1:0] ee_addr;
  logic [FL_PAGE_W-1:0] fl_page;
  logic [EE_PAGE_W-1:0] ee_page;

  logic [15:0] fl_mem [FL_DEPTH];
  logic [7:0]  ee_mem [EE_DEPTH];
  logic [15:0] fl_rd;
  logic [7:0]  ee_rd;

  logic       reject_d, rsp_valid_d;
  logic [7:0] rsp_data_d;

  assign op      = prog_op_e'(cmd_op);
  assign fl_addr = cmd_addr[FL_ADDR_W-1:0];
  assign ee_addr = cmd_addr[EE_ADDR_W-1:0];
  assign fl_page = fl_addr[FL_ADDR_W-1:FL_WORD_W];
  assign ee_page = ee_addr[EE_ADDR_W-1:EE_BYTE_W];

  always_comb begin
    is_poll = (op == OP_POLL);
    is_read = (op == OP_RD_FL_LO) || (op == OP_RD_FL_HI) || (op == OP_RD_EE);
    go      = cmd_valid && !busy;
    blocked = cmd_valid && busy && (cmd_op >= 4'd1) && (cmd_op <= 4'd9);
    fl_lo     = go && (op == OP_FL_LO);
    fl_hi     = go && (op == OP_FL_HI);
    fl_commit = go && (op == OP_FL_COMMIT);
    ee_load   = go && (op == OP_EE_LOAD);
    ee_commit = go && (op == OP_EE_COMMIT);
    ee_byte   = go && (op == OP_EE_BYTE);
    tmr_start = fl_commit || ee_commit || ee_byte;
    tmr_load  = fl_commit ? CNT_W'(FL_WAIT) : CNT_W'(EE_WAIT);
  end

  fl_page_buf #(.WORD_W(FL_WORD_W)) u_fl_buf (
    .clk       (clk),
    .rst_n     (rst_n),
    .ld_lo     (fl_lo),
    .ld_hi     (fl_hi),
    .clr       (fl_commit),
    .idx       (fl_addr[FL_WORD_W-1:0]),
    .din       (cmd_data),
    .hi_orphan (hi_orphan),
    .words     (fl_words)
  );

  ee_page_buf #(.BYTE_W(EE_BYTE_W)) u_ee_buf (
    .clk   (clk),
    .rst_n (rst_n),
    .ld    (ee_load),
    .clr   (ee_commit),
    .idx   (ee_addr[EE_BYTE_W-1:0]),
    .din   (cmd_data),
    .bytes (ee_bytes),
    .mask  (ee_mask)
  );

  prog_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (tmr_start),
    .load_val (tmr_load),
    .busy     (busy)
  );

  // Behavioural storage: contents are not reset.
  always_ff @(posedge clk) begin
    if (fl_commit) begin
      for (int w = 0; w < FL_WORDS; w++) begin
        fl_mem[{fl_page, FL_WORD_W'(w)}] <= fl_words[w];
      end
    end
    if (ee_commit) begin
      for (int b = 0; b < EE_BYTES; b++) begin
        if (ee_mask[b]) ee_mem[{ee_page, EE_BYTE_W'(b)}] <= ee_bytes[b];
      end
    end
    if (ee_byte) ee_mem[ee_addr] <= cmd_data;
  end

  assign fl_rd = fl_mem[fl_addr];
  assign ee_rd = ee_mem[ee_addr];

  always_comb begin
    reject_d    = blocked || hi_orphan;
    rsp_valid_d = cmd_valid && (is_poll || (go && is_read));
    case (op)
      OP_RD_FL_LO: rsp_data_d = fl_rd[7:0];
      OP_RD_FL_HI: rsp_data_d = fl_rd[15:8];
      OP_RD_EE:    rsp_data_d = ee_rd;
      default:     rsp_data_d = {7'd0, busy};
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reject    <= 1'b0;
      rsp_valid <= 1'b0;
    end else begin
      reject    <= reject_d;
      rsp_valid <= rsp_valid_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           rsp_data <= '0;
    else if (rsp_valid_d) rsp_data <= rsp_data_d;
  end
endmodule

// File: rtl/nvm_prog_chk.sv
module nvm_prog_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_valid,
  input logic [3:0] cmd_op,
  input logic       busy,
  input logic       reject,
  input logic       rsp_valid,
  input logic [7:0] rsp_data
);
  // R7: an accepted commit or byte write starts the busy window
  assert_commit_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !busy && (cmd_op == 4'd3 || cmd_op == 4'd5 || cmd_op == 4'd6) |=> busy);

  // R9: memory instructions issued while busy are flagged
  assert_busy_reject_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && busy && cmd_op >= 4'd1 && cmd_op <= 4'd9 |=> reject && !rsp_valid);

  // R8: poll answers with the busy state seen with the instruction
  assert_poll_reply_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_op == 4'd10 |=> rsp_valid && rsp_data == {7'd0, $past(busy)});

  // R10: a refusal never comes with a response
  assert_rsp_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    reject |-> !rsp_valid);

  // R10: a no-op is silent
  assert_nop_silent_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_op == 4'd0 |=> !rsp_valid && !reject);
endmodule

bind nvm_page_prog nvm_prog_chk u_chk (.*);

// File: tb/test_nvm_page_prog.sv
module test_nvm_page_prog;
  localparam int FLW = 12;
  localparam int EEW = 8;

  logic        clk;
  logic        rst_n;
  logic        cmd_valid;
  logic [3:0]  cmd_op;
  logic [10:0] cmd_addr;
  logic [7:0]  cmd_data;
  logic        busy, reject, rsp_valid;
  logic [7:0]  rsp_data;

  int n_chk = 0;
  int n_fail = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  nvm_page_prog #(.FL_WAIT(FLW), .EE_WAIT(EEW)) i_nvm_page_prog (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data), .busy(busy), .reject(reject),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Monitor: pops expected responses as the design produces them
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R10 unexpected response", rsp_data, 0);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(rsp_data == e, t, rsp_data, e);
      end
    end
  end

  // Driver: one instruction, returns the reject flag of the next cycle
  task automatic send(input logic [3:0] op, input logic [10:0] addr,
                      input logic [7:0] data, output bit rej);
    @(negedge clk);
    if (op == 4'd10) begin
      exp_q.push_back({7'd0, busy});
      tag_q.push_back("R8 poll value");
    end
    cmd_valid = 1'b1;
    cmd_op    = op;
    cmd_addr  = addr;
    cmd_data  = data;
    @(negedge clk);
    cmd_valid = 1'b0;
    rej = reject;
  endtask

  task automatic rd(input logic [3:0] op, input logic [10:0] addr,
                    input logic [7:0] e, input string tag);
    bit rej;
    exp_q.push_back(e);
    tag_q.push_back(tag);
    send(op, addr, 8'h00, rej);
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (busy) begin
      n++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    bit rej;
    int n;
    cmd_valid = 1'b0;
    cmd_op = '0;
    cmd_addr = '0;
    cmd_data = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(!busy && !reject && !rsp_valid, "R1 reset outputs", {busy, reject, rsp_valid}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !reject && !rsp_valid, "R1 after release", {busy, reject, rsp_valid}, 0);

    // R2/R3: fill page 3; word 5 skipped, word 7 gets only a high byte
    for (int w = 0; w < 32; w++) begin
      if (w == 7) begin
        send(4'd2, {6'h15, 5'(w)}, 8'hEE, rej);
        chk(rej, "R3 high byte without low refused", rej, 1);
      end else if (w != 5) begin
        send(4'd1, {6'h2A, 5'(w)}, 8'(w * 3 + 1), rej);
        send(4'd2, {6'h15, 5'(w)}, 8'hA0 ^ 8'(w), rej);
      end
    end
    send(4'd3, {6'd3, 5'h1A}, 8'h00, rej);
    chk(!rej, "R2 commit accepted", rej, 0);
    wait_idle(n);
    chk(n == FLW, "R7 flash busy length", n, FLW);
    for (int w = 0; w < 32; w++) begin
      if (w == 5 || w == 7) begin
        rd(4'd7, {6'd3, 5'(w)}, 8'hFF, "R3 R4 unloaded word low");
        rd(4'd8, {6'd3, 5'(w)}, 8'hFF, "R3 R4 unloaded word high");
      end else begin
        rd(4'd7, {6'd3, 5'(w)}, 8'(w * 3 + 1), "R2 word low byte");
        rd(4'd8, {6'd3, 5'(w)}, 8'hA0 ^ 8'(w), "R2 word high byte");
      end
    end

    // R9: refused low byte while busy leaves no pending entry
    send(4'd1, 11'd2, 8'h5A, rej);
    send(4'd2, 11'd2, 8'h6B, rej);
    send(4'd3, {6'd9, 5'd0}, 8'h00, rej);
    send(4'd1, 11'd0, 8'h12, rej);
    chk(rej, "R9 load refused while busy", rej, 1);
    chk(busy, "R8 busy before poll", busy, 1);
    send(4'd10, 11'd0, 8'h00, rej);
    chk(!rej, "R8 poll accepted while busy", rej, 0);
    wait_idle(n);
    send(4'd2, 11'd0, 8'h34, rej);
    chk(rej, "R9 refused low byte had no effect", rej, 1);
    send(4'd3, {6'd4, 5'd0}, 8'h00, rej);
    wait_idle(n);
    rd(4'd7, {6'd9, 5'd2}, 8'h5A, "R2 page 9 word 2 low");
    rd(4'd8, {6'd9, 5'd2}, 8'h6B, "R2 page 9 word 2 high");
    rd(4'd7, {6'd4, 5'd0}, 8'hFF, "R9 page 4 word 0 low");
    rd(4'd8, {6'd4, 5'd3}, 8'hFF, "R4 buffer refilled after commit");
    send(4'd10, 11'd0, 8'h00, rej);

    // R6/R7: byte writes to data page 5
    for (int b = 0; b < 4; b++) begin
      send(4'd6, {3'd0, 6'd5, 2'(b)}, 8'h50 + 8'(b), rej);
      wait_idle(n);
      if (b == 0) chk(n == EEW, "R7 data busy length", n, EEW);
    end
    for (int b = 0; b < 4; b++) rd(4'd9, {3'd0, 6'd5, 2'(b)}, 8'h50 + 8'(b), "R6 byte write");

    // R5: partial page load only alters marked bytes
    send(4'd4, {3'd0, 6'h3F, 2'd1}, 8'hC1, rej);
    send(4'd4, {3'd0, 6'h00, 2'd3}, 8'hC3, rej);
    send(4'd5, {3'd0, 6'd5, 2'd2}, 8'h00, rej);
    wait_idle(n);
    rd(4'd9, {3'd0, 6'd5, 2'd0}, 8'h50, "R5 unmarked byte 0 kept");
    rd(4'd9, {3'd0, 6'd5, 2'd1}, 8'hC1, "R5 marked byte 1");
    rd(4'd9, {3'd0, 6'd5, 2'd2}, 8'h52, "R5 unmarked byte 2 kept");
    rd(4'd9, {3'd0, 6'd5, 2'd3}, 8'hC3, "R5 marked byte 3");

    send(4'd6, {3'd0, 6'd5, 2'd1}, 8'h77, rej);
    wait_idle(n);
    send(4'd5, {3'd0, 6'd5, 2'd0}, 8'h00, rej);
    wait_idle(n);
    rd(4'd9, {3'd0, 6'd5, 2'd1}, 8'h77, "R5 R6 mask cleared, byte write kept");
    rd(4'd9, {3'd0, 6'd5, 2'd3}, 8'hC3, "R5 empty commit keeps byte 3");

    // R10: no-op and unused codes are silent
    send(4'd0, 11'd0, 8'h00, rej);
    chk(!rej && !rsp_valid, "R10 no-op silent", {rej, rsp_valid}, 0);
    send(4'd13, 11'd0, 8'h00, rej);
    chk(!rej && !rsp_valid, "R10 unused code silent", {rej, rsp_valid}, 0);

    repeat (2) @(negedge clk);
    chk(exp_q.size() == 0, "R10 responses outstanding", exp_q.size(), 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule